// File: doc/BRIEF.md
# Binary Search Tree Minimum and Delete Engine

This engine works on a binary search tree kept in an external node RAM. Each node word holds a value, a repeat count, and a left and a right child address. Address 0 is always the root slot, and a child address of 0 means "no child". Two commands are handled, one at a time. Find-minimum follows left links from the root and reports the smallest value together with its count. Delete looks up a key and unlinks the matching node. The search order of the tree is kept intact, so a later walk of the tree still visits the values in ascending order.

When the matching node has a right child, the right child moves up into the matching node's slot. Before that move, the old left subtree is hung below the right child's subtree, at the first empty link found by searching with the left child's value. When the matching node has only a left child, that child moves up. A leaf is unlinked from its parent. Each slot that becomes unused leaves the engine on a free-address stream, so that a separate insert engine can use it again.

Commands arrive on a valid/ready stream and results leave on a valid/ready stream. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. A result stays on the port until it is taken on an edge where both `res_valid` and `res_ready` are high. The free-address stream follows the same rules. A stalled free stream never stalls the command flow.

Top module: `btree_min_del`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle with no result pending. A command is taken on an edge with `cmd_valid` and `cmd_ready` both high. The opcode `cmd_op` is 0 for find-minimum and 1 for delete. After a result is taken, the engine is ready again on the next cycle.
- R2: While `res_valid` is high and `res_ready` is low, the engine holds `res_valid`, `res_found`, `res_value` and `res_count` unchanged.
- R3: A node word is packed, from the most significant bit down, as value, count, left address, right address. Address 0 is the root, and a link of 0 means no child. The tree is empty when the root word has count 0. Deleting a root that has no children writes an all-zero word to the root.
- R4: Find-minimum on a non-empty tree returns the value and count of the node reached by following left links from the root, with `res_found` = 1.
- R5: Find-minimum on an empty tree returns `res_found` = 0. Any result with `res_found` = 0 has `res_value` and `res_count` equal to 0.
- R6: A delete whose key is not in the tree returns `res_found` = 0. It writes nothing to node RAM and emits no free address.
- R7: Deleting a node with no children clears the parent's link to it and emits its address as free. A childless root is handled as in R3, and no address is emitted.
- R8: Deleting a node with a right child works in three steps. First, it links the old left subtree, if there is one, at the first zero link reached by searching the right child's subtree with the left child's value. Then it copies the right child's word into the deleted node's slot. Finally, it emits the right child's address as free.
- R9: Deleting a node with only a left child copies the left child's word into the deleted node's slot and emits the left child's address as free.
- R10: A successful delete returns `res_found` = 1 with the deleted value and its count. After the delete, an in-order walk yields exactly the remaining values, strictly ascending, each with its own count.
- R11: Freed addresses leave on `free_valid`/`free_ready` in the order they were freed. A pending address is held until it is taken. Address 0 is never emitted.
- R12: Node RAM has one access per cycle and a read latency of one cycle. `mem_rd` and `mem_we` are never high in the same cycle, and neither is high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 1 | 0 = find-minimum, 1 = delete |
| cmd_key | input | VAL_W | Key for delete |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Consumer takes the result |
| res_found | output | 1 | Node found (minimum exists or key matched) |
| res_value | output | VAL_W | Minimum value or deleted value |
| res_count | output | CNT_W | Repeat count of that node |
| mem_rd | output | 1 | Node RAM read strobe |
| mem_we | output | 1 | Node RAM write strobe |
| mem_addr | output | ADDR_W | Node RAM address |
| mem_wdata | output | VAL_W+CNT_W+2*ADDR_W | Node word to write |
| mem_rdata | input | VAL_W+CNT_W+2*ADDR_W | Node word read, one cycle after `mem_rd` |
| free_valid | output | 1 | Freed slot address offered |
| free_ready | input | 1 | Consumer takes the freed address |
| free_addr | output | ADDR_W | Freed slot address |

## Verification
The assertions check the stream rules on every cycle. These are that results and free addresses are held under back-pressure, that the engine is ready again after a result is taken, that address 0 is never emitted, and that RAM access is single-ported and quiet when idle. They also check that a result with no match carries zero value and count.

Only the bench scenarios can show the structural behaviour. This covers which link is cleared for a leaf, where the left subtree lands under the right child, which slot is copied and which is freed, and that the tree stays ordered with its counts intact. The bench shows this by walking the RAM after each command and comparing it with a model of the remaining value set.

// File: rtl/btdel_pkg.sv
package btdel_pkg;

  typedef enum logic {
    OP_FIND_MIN = 1'b0,
    OP_DELETE   = 1'b1
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WALK_RQ,
    ST_WALK,
    ST_LEAF,
    ST_LFET_RQ,
    ST_LFET,
    ST_ATT_RQ,
    ST_ATT,
    ST_COPY_RQ,
    ST_COPY,
    ST_RESP
  } state_e;

endpackage

// File: rtl/btdel_key_cmp.sv
module btdel_key_cmp #(
  parameter int VAL_W = 8
) (
  input  logic [VAL_W-1:0] key_a,
  input  logic [VAL_W-1:0] node_b,
  output logic             a_lt_b,
  output logic             a_eq_b
);
  assign a_lt_b = key_a < node_b;
  assign a_eq_b = key_a == node_b;
endmodule

// File: rtl/btdel_free_fifo.sv
module btdel_free_fifo #(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [ADDR_W-1:0] slots [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     fill;
  logic              full, wr_en, rd_en;

  assign full      = fill == CW'(DEPTH);
  assign out_valid = fill != '0;
  assign out_addr  = slots[rp];
  assign wr_en     = push && !full;
  assign rd_en     = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr_en) slots[wp] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/btree_min_del.sv
module btree_min_del
  import btdel_pkg::*;
#(
  parameter int VAL_W  = 8,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_valid,
  output logic                            cmd_ready,
  input  logic                            cmd_op,
  input  logic [VAL_W-1:0]                cmd_key,
  output logic                            res_valid,
  input  logic                            res_ready,
  output logic                            res_found,
  output logic [VAL_W-1:0]                res_value,
  output logic [CNT_W-1:0]                res_count,
  output logic                            mem_rd,
  output logic                            mem_we,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic [VAL_W+CNT_W+2*ADDR_W-1:0] mem_wdata,
  input  logic [VAL_W+CNT_W+2*ADDR_W-1:0] mem_rdata,
  output logic                            free_valid,
  input  logic                            free_ready,
  output logic [ADDR_W-1:0]               free_addr
);
  localparam int NODE_W   = VAL_W + CNT_W + 2 * ADDR_W;
  localparam int R_LO     = 0;
  localparam int L_LO     = ADDR_W;
  localparam int C_LO     = 2 * ADDR_W;
  localparam int V_LO     = 2 * ADDR_W + CNT_W;
  localparam int FL_DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] NIL = '0;

  state_e             st;
  op_e                op_q;
  logic [VAL_W-1:0]   key_q, lval;
  logic [ADDR_W-1:0]  cur, par, tgt, src, tgt_left;
  logic [NODE_W-1:0]  par_node;
  logic               par_right;

  logic [VAL_W-1:0]   rd_val;
  logic [CNT_W-1:0]   rd_cnt;
  logic [ADDR_W-1:0]  rd_left, rd_right;
  logic [VAL_W-1:0]   cmp_a;
  logic               k_lt, k_eq;
  logic               push;
  logic [ADDR_W-1:0]  push_addr;

  assign rd_val   = mem_rdata[V_LO +: VAL_W];
  assign rd_cnt   = mem_rdata[C_LO +: CNT_W];
  assign rd_left  = mem_rdata[L_LO +: ADDR_W];
  assign rd_right = mem_rdata[R_LO +: ADDR_W];

  // One comparator serves both the key search and the reattach descent
  assign cmp_a = (st == ST_ATT) ? lval : key_q;

  btdel_key_cmp #(.VAL_W(VAL_W)) u_cmp (
    .key_a  (cmp_a),
    .node_b (rd_val),
    .a_lt_b (k_lt),
    .a_eq_b (k_eq)
  );

  btdel_free_fifo #(.ADDR_W(ADDR_W), .DEPTH(FL_DEPTH)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (push_addr),
    .out_valid (free_valid),
    .out_ready (free_ready),
    .out_addr  (free_addr)
  );

  assign cmd_ready = (st == ST_IDLE);
  assign res_valid = (st == ST_RESP);

  // RAM port and free-list push, decoded from the current state
  always_comb begin
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    push      = 1'b0;
    push_addr = src;
    case (st)
      ST_WALK_RQ, ST_ATT_RQ: mem_rd = 1'b1;
      ST_LFET_RQ: begin
        mem_rd   = 1'b1;
        mem_addr = tgt_left;
      end
      ST_COPY_RQ: begin
        mem_rd   = 1'b1;
        mem_addr = src;
      end
      ST_LEAF: begin
        mem_we = 1'b1;
        if (tgt == NIL) begin
          mem_addr  = NIL;
          mem_wdata = '0;
        end else begin
          mem_addr  = par;
          mem_wdata = par_node;
          if (par_right) mem_wdata[R_LO +: ADDR_W] = NIL;
          else           mem_wdata[L_LO +: ADDR_W] = NIL;
          push      = 1'b1;
          push_addr = tgt;
        end
      end
      ST_ATT: begin
        mem_wdata = mem_rdata;
        if (k_lt && rd_left == NIL) begin
          mem_we = 1'b1;
          mem_wdata[L_LO +: ADDR_W] = tgt_left;
        end else if (!k_lt && rd_right == NIL) begin
          mem_we = 1'b1;
          mem_wdata[R_LO +: ADDR_W] = tgt_left;
        end
      end
      ST_COPY: begin
        mem_we    = 1'b1;
        mem_addr  = tgt;
        mem_wdata = mem_rdata;
        push      = 1'b1;
        push_addr = src;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op_q      <= OP_FIND_MIN;
      key_q     <= '0;
      lval      <= '0;
      cur       <= NIL;
      par       <= NIL;
      tgt       <= NIL;
      src       <= NIL;
      tgt_left  <= NIL;
      par_node  <= '0;
      par_right <= 1'b0;
      res_found <= 1'b0;
      res_value <= '0;
      res_count <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cmd_valid) begin
          op_q  <= op_e'(cmd_op);
          key_q <= cmd_key;
          cur   <= NIL;
          st    <= ST_WALK_RQ;
        end
        ST_WALK_RQ: st <= ST_WALK;
        ST_WALK: begin
          if (cur == NIL && rd_cnt == '0) begin
            res_found <= 1'b0;
            res_value <= '0;
            res_count <= '0;
            st        <= ST_RESP;
          end else if (op_q == OP_FIND_MIN) begin
            if (rd_left != NIL) begin
              cur <= rd_left;
              st  <= ST_WALK_RQ;
            end else begin
              res_found <= 1'b1;
              res_value <= rd_val;
              res_count <= rd_cnt;
              st        <= ST_RESP;
            end
          end else if (k_eq) begin
            tgt       <= cur;
            tgt_left  <= rd_left;
            res_found <= 1'b1;
            res_value <= rd_val;
            res_count <= rd_cnt;
            if (rd_left == NIL && rd_right == NIL) begin
              st <= ST_LEAF;
            end else if (rd_right != NIL) begin
              src <= rd_right;
              st  <= (rd_left != NIL) ? ST_LFET_RQ : ST_COPY_RQ;
            end else begin
              src <= rd_left;
              st  <= ST_COPY_RQ;
            end
          end else begin
            if ((k_lt ? rd_left : rd_right) == NIL) begin
              res_found <= 1'b0;
              res_value <= '0;
              res_count <= '0;
              st        <= ST_RESP;
            end else begin
              par       <= cur;
              par_node  <= mem_rdata;
              par_right <= !k_lt;
              cur       <= k_lt ? rd_left : rd_right;
              st        <= ST_WALK_RQ;
            end
          end
        end
        ST_LEAF:    st <= ST_RESP;
        ST_LFET_RQ: st <= ST_LFET;
        ST_LFET: begin
          lval <= rd_val;
          cur  <= src;
          st   <= ST_ATT_RQ;
        end
        ST_ATT_RQ: st <= ST_ATT;
        ST_ATT: begin
          if (k_lt) begin
            if (rd_left == NIL) st <= ST_COPY_RQ;
            else begin
              cur <= rd_left;
              st  <= ST_ATT_RQ;
            end
          end else begin
            if (rd_right == NIL) st <= ST_COPY_RQ;
            else begin
              cur <= rd_right;
              st  <= ST_ATT_RQ;
            end
          end
        end
        ST_COPY_RQ: st <= ST_COPY;
        ST_COPY:    st <= ST_RESP;
        ST_RESP:    if (res_ready) st <= ST_IDLE;
        default:    st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/btdel_checker.sv
module btdel_checker #(
  parameter int VAL_W  = 8,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_found,
  input logic [VAL_W-1:0]  res_value,
  input logic [CNT_W-1:0]  res_count,
  input logic              mem_rd,
  input logic              mem_we,
  input logic              free_valid,
  input logic              free_ready,
  input logic [ADDR_W-1:0] free_addr
);
  a_r1_ready_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> cmd_ready);

  a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_found)
      && $stable(res_value) && $stable(res_count));

  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_found |-> res_value == '0 && res_count == '0);

  a_r11_free_hold: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid && !free_ready |=> free_valid && $stable(free_addr));

  a_r11_never_root: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> free_addr != '0);

  a_r12_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_rd && !mem_we);
endmodule

bind btree_min_del btdel_checker #(
  .VAL_W(VAL_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_btree_min_del.sv
module tb_btree_min_del;
  localparam int VAL_W  = 8;
  localparam int CNT_W  = 4;
  localparam int ADDR_W = 5;
  localparam int NODE_W = VAL_W + CNT_W + 2 * ADDR_W;
  localparam int SLOTS  = 1 << ADDR_W;
  localparam int NVEC   = 17;

  typedef struct packed {
    logic             op;
    logic [VAL_W-1:0] key;
    logic             fnd;
    logic [VAL_W-1:0] val;
    logic [CNT_W-1:0] cnt;
    logic [ADDR_W-1:0] fr;
  } vec_t;

  // op: 0 find-min, 1 delete; fr = expected freed slot, 0 = none
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'd0,  1'b1, 8'd11, 4'd1, 5'd0},  // R4
    '{1'b1, 8'd11, 1'b1, 8'd11, 4'd1, 5'd2},  // R7 leaf
    '{1'b0, 8'd0,  1'b1, 8'd17, 4'd1, 5'd0},  // R4
    '{1'b1, 8'd50, 1'b0, 8'd0,  4'd0, 5'd0},  // R6 miss right
    '{1'b1, 8'd10, 1'b0, 8'd0,  4'd0, 5'd0},  // R6 miss left
    '{1'b1, 8'd28, 1'b1, 8'd28, 4'd1, 5'd6},  // R8 both children
    '{1'b0, 8'd0,  1'b1, 8'd17, 4'd1, 5'd0},  // R4
    '{1'b1, 8'd17, 1'b1, 8'd17, 4'd1, 5'd5},  // R8 right only
    '{1'b1, 8'd19, 1'b1, 8'd19, 4'd1, 5'd3},  // R8 at root
    '{1'b0, 8'd0,  1'b1, 8'd18, 4'd1, 5'd0},  // R4
    '{1'b1, 8'd34, 1'b1, 8'd34, 4'd1, 5'd7},  // R9 root left only
    '{1'b1, 8'd25, 1'b1, 8'd25, 4'd3, 5'd1},  // R9 count carried
    '{1'b1, 8'd18, 1'b1, 8'd18, 4'd1, 5'd4},  // R7 leaf under root
    '{1'b0, 8'd0,  1'b1, 8'd31, 4'd1, 5'd0},  // R4 root has no left
    '{1'b1, 8'd31, 1'b1, 8'd31, 4'd1, 5'd0},  // R3 root leaf empties
    '{1'b0, 8'd0,  1'b0, 8'd0,  4'd0, 5'd0},  // R5 empty tree
    '{1'b1, 8'd31, 1'b0, 8'd0,  4'd0, 5'd0}   // R6 empty tree
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_op = 1'b0, res_ready = 1'b0, free_ready = 1'b1;
  logic [VAL_W-1:0] cmd_key = '0;
  logic cmd_ready, res_valid, res_found, mem_rd, mem_we, free_valid;
  logic [VAL_W-1:0]  res_value;
  logic [CNT_W-1:0]  res_count;
  logic [ADDR_W-1:0] mem_addr, free_addr;
  logic [NODE_W-1:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  btree_min_del #(.VAL_W(VAL_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_key(cmd_key), .res_valid(res_valid),
    .res_ready(res_ready), .res_found(res_found), .res_value(res_value),
    .res_count(res_count), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .free_valid(free_valid), .free_ready(free_ready), .free_addr(free_addr)
  );

  logic [NODE_W-1:0] ram [SLOTS];
  int wr_cnt = 0, pop_cnt = 0, clash_cnt = 0;
  logic [ADDR_W-1:0] last_pop = '0;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
    if (mem_we) wr_cnt <= wr_cnt + 1;
    if (mem_we && mem_rd) clash_cnt <= clash_cnt + 1;
    if (free_valid && free_ready) begin
      pop_cnt  <= pop_cnt + 1;
      last_pop <= free_addr;
    end
  end

  int checks = 0, fails = 0;
  bit present [256];
  int mcount [256];
  int nxt_slot = 0;

  function automatic logic [NODE_W-1:0] mk(input int v, input int c, input int l, input int r);
    return {VAL_W'(v), CNT_W'(c), ADDR_W'(l), ADDR_W'(r)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bench-side tree builder (construction is outside the engine)
  task automatic bt_insert(input int v, input int c);
    int a;
    bit done;
    a = 0;
    done = 0;
    if (nxt_slot != 0) begin
      while (!done) begin
        if (v < int'(ram[a][NODE_W-1 -: VAL_W])) begin
          if (ram[a][ADDR_W +: ADDR_W] == '0) begin
            ram[a][ADDR_W +: ADDR_W] = ADDR_W'(nxt_slot); done = 1;
          end else a = int'(ram[a][ADDR_W +: ADDR_W]);
        end else begin
          if (ram[a][ADDR_W-1:0] == '0) begin
            ram[a][ADDR_W-1:0] = ADDR_W'(nxt_slot); done = 1;
          end else a = int'(ram[a][ADDR_W-1:0]);
        end
      end
    end
    ram[nxt_slot] = mk(v, c, 0, 0);
    present[v] = 1;
    mcount[v] = c;
    nxt_slot++;
  endtask

  // In-order walk of RAM compared against the model set
  task automatic tree_check(input string tag);
    int stk [SLOTS];
    int sp, c, steps, seen, expn, prev, v, errv;
    bit cv, ok;
    ok = 1; sp = 0; steps = 0; seen = 0; prev = -1; errv = 0; expn = 0;
    for (int i = 0; i < 256; i++) if (present[i]) expn++;
    if (ram[0][2*ADDR_W +: CNT_W] == '0) begin
      chk(expn == 0, {tag, " R3 empty root"}, 0, expn);
      return;
    end
    c = 0; cv = 1;
    while (steps < 200) begin
      steps++;
      if (cv) begin
        stk[sp] = c; sp++;
        cv = ram[c][ADDR_W +: ADDR_W] != '0;
        c = int'(ram[c][ADDR_W +: ADDR_W]);
      end else if (sp > 0) begin
        sp--; c = stk[sp];
        v = int'(ram[c][NODE_W-1 -: VAL_W]);
        if (v <= prev || !present[v] || mcount[v] != int'(ram[c][2*ADDR_W +: CNT_W])) begin
          ok = 0; errv = v;
        end
        prev = v; seen++;
        cv = ram[c][ADDR_W-1:0] != '0;
        c = int'(ram[c][ADDR_W-1:0]);
      end else break;
    end
    chk(ok && seen == expn, {tag, " R10 tree order/content"}, ok ? seen : errv, expn);
  endtask

  task automatic run_cmd(input logic op, input logic [VAL_W-1:0] k,
                         output logic f, output logic [VAL_W-1:0] v,
                         output logic [CNT_W-1:0] c, output bit held);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_key = k;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    f = res_found; v = res_value; c = res_count;
    held = 1;
    repeat (2) begin
      @(negedge clk);
      if (!res_valid || res_found !== f || res_value !== v || res_count !== c) held = 0;
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic f;
    logic [VAL_W-1:0] v;
    logic [CNT_W-1:0] c;
    bit held;
    int w0, p0;
    string tag;

    for (int i = 0; i < SLOTS; i++) ram[i] = '0;
    bt_insert(19, 1); bt_insert(17, 1); bt_insert(11, 1); bt_insert(28, 1);
    bt_insert(25, 3); bt_insert(18, 1); bt_insert(34, 1); bt_insert(31, 1);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready === 1'b1, "R1 reset cmd_ready", int'(cmd_ready), 1);
    chk(res_valid === 1'b0, "R2 reset res_valid", int'(res_valid), 0);
    chk(free_valid === 1'b0, "R11 reset free_valid", int'(free_valid), 0);
    chk(mem_we === 1'b0 && mem_rd === 1'b0, "R12 reset idle RAM", int'(mem_we), 0);

    for (int n = 0; n < NVEC; n++) begin
      w0 = wr_cnt; p0 = pop_cnt;
      if (VEC[n].op == 1'b0) tag = VEC[n].fnd ? "R4" : "R5";
      else                   tag = VEC[n].fnd ? "R10" : "R6";
      run_cmd(VEC[n].op, VEC[n].key, f, v, c, held);
      chk(f === VEC[n].fnd, $sformatf("%s vec%0d found", tag, n), int'(f), int'(VEC[n].fnd));
      chk(v === VEC[n].val && c === VEC[n].cnt,
          $sformatf("%s vec%0d value/count", tag, n), int'(v), int'(VEC[n].val));
      chk(held, $sformatf("R2 vec%0d result hold", n), 0, 1);
      if (VEC[n].fr != '0)
        chk(pop_cnt - p0 == 1 && last_pop == VEC[n].fr,
            $sformatf("R11 vec%0d freed slot (R7/R8/R9)", n), int'(last_pop), int'(VEC[n].fr));
      else
        chk(pop_cnt == p0, $sformatf("R11 vec%0d nothing freed", n), pop_cnt - p0, 0);
      if (VEC[n].op == 1'b1 && !VEC[n].fnd)
        chk(wr_cnt == w0, $sformatf("R6 vec%0d no RAM write", n), wr_cnt - w0, 0);
      if (VEC[n].op == 1'b1 && VEC[n].fnd) present[VEC[n].key] = 0;
      tree_check($sformatf("vec%0d", n));
    end

    // R3 root cleared to all zero after the last root leaf delete
    chk(ram[0] == '0, "R3 root word zero", int'(ram[0][NODE_W-1 -: VAL_W]), 0);

    // R11 back-pressure and ordering on the free stream
    for (int i = 0; i < SLOTS; i++) ram[i] = '0;
    nxt_slot = 0;
    bt_insert(5, 2); bt_insert(3, 1); bt_insert(8, 4);
    free_ready = 1'b0;
    run_cmd(1'b1, 8'd3, f, v, c, held);   // R7 leaf left of root, slot 1
    present[3] = 0;
    run_cmd(1'b1, 8'd8, f, v, c, held);   // R7 leaf right of root, slot 2
    present[8] = 0;
    chk(f === 1'b1 && c === 4'd4, "R10 delete 8 count", int'(c), 4);
    chk(free_valid === 1'b1 && free_addr == 5'd1, "R11 held first freed", int'(free_addr), 1);
    repeat (4) @(negedge clk);
    chk(free_valid === 1'b1 && free_addr == 5'd1, "R11 stable under stall", int'(free_addr), 1);
    free_ready = 1'b1;
    @(negedge clk);
    chk(free_valid === 1'b1 && free_addr == 5'd2, "R11 second freed in order", int'(free_addr), 2);
    @(negedge clk);
    chk(free_valid === 1'b0, "R11 list drained", int'(free_valid), 0);
    tree_check("bp");
    run_cmd(1'b0, 8'd0, f, v, c, held);
    chk(f === 1'b1 && v == 8'd5 && c == 4'd2, "R4 single root min", int'(v), 5);

    chk(clash_cnt == 0, "R12 no read and write together", clash_cnt, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule